// File: doc/BRIEF.md
# Accumulator Result Unit

This block is the combinational result path of an 8-bit accumulator machine. Given the current instruction byte, the optional second (immediate) byte, the accumulator value and the value of the general register that the instruction selects, it produces the next accumulator value and a write enable for it. It also produces the value and write enable for the selected general register, which covers register moves and the exchange between the accumulator and a register. Memory access, branching and sequencing belong to other blocks. The instruction fetch logic presents the second byte on `immByte` whenever the first byte is one of the two-byte forms. For every other instruction `immByte` is ignored.

Inside, a decoder turns the instruction bytes into a small struct of strobes: a source select, a 3-bit sub-operation and two write enables. A datapath module computes every candidate result and uses the strobes to pick one. A thin top module joins the two.

Top module: `accAluCore`

## Requirements
- R1: For `opByte` = 0000_1sss, the accumulator is written with, by sss = 0..7: zero, shift left by 1, logical shift right by 1, arithmetic shift right by 1, plus 1, minus 1, bitwise complement, two's-complement negation (all modulo 256).
- R2: For `opByte` = 01ss_sxxx, the accumulator is written with `accIn` combined with `regIn` by, for sss = 0..7: add, subtract (accIn − regIn), and, or, xor, shift left, logical shift right, arithmetic shift right. Shift amounts are `regIn[2:0]`.
- R3: For `opByte` = 0011_1xxx, the accumulator is written with 1 when `accIn` < `regIn` as unsigned numbers, and with 0 otherwise.
- R4: `opByte` = 0010_0xxx writes `regIn` to the accumulator. `opByte` = 0010_1xxx writes `accIn` to the register and leaves the accumulator alone. `opByte` = 0011_0xxx writes `regIn` to the accumulator and `accIn` to the register in the same step. No other opcode asserts `regWrite`.
- R5: For `opByte` = 1111_00ss with ss = 00, 01, 10, the accumulator is written with `accIn` and / or / xor `immByte`.
- R6: For `opByte` = 1111_0011 with `immByte[7]` = 0, the accumulator is written with `accIn` + `immByte[6:0]`, the 7-bit field taken as unsigned.
- R7: For `opByte` = 1111_0011 with `immByte[7:6]` = 11, the accumulator is written with `accIn` + `immByte` modulo 256, so the whole byte acts as a negative constant.
- R8: For `opByte` = 1111_0011 with `immByte` = 10sssnnn, the accumulator is written with, for sss = 0..7: rotate left by nnn, shift left by nnn, logical shift right by nnn, arithmetic shift right by nnn, clear bit nnn, set bit nnn, toggle bit nnn, or bit nnn moved to bit 0 with all other bits zero.
- R9: For `opByte` = 1111_1110, the accumulator is written with `immByte`.
- R10: For every opcode not listed above, `accWrite` and `regWrite` are 0, `accOut` equals `accIn` and `regOut` equals `regIn`. Whenever a write enable is 0, its output equals the matching input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opByte | input | 8 | First instruction byte |
| immByte | input | 8 | Second instruction byte, used by two-byte forms |
| accIn | input | 8 | Current accumulator value |
| regIn | input | 8 | Value of the register selected by the low three opcode bits |
| accOut | output | 8 | New accumulator value |
| accWrite | output | 1 | Accumulator write enable |
| regOut | output | 8 | New value for the selected register |
| regWrite | output | 1 | Register write enable |

## Verification
The assertions are immediate checks on the settled combinational outputs. They take for granted that all four inputs hold known two-state values and are stable when the outputs are read, and that `immByte` only matters after a first byte of 1111_00ss or 1111_1110. The stimulus changes all inputs together once per cycle, just after the clock edge, and reads the outputs half a cycle later. It also drives random second bytes with every opcode, so that a non-immediate opcode that reacts to `immByte` would show up.

// File: rtl/accAluPkg.sv
package accAluPkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int SUB_W  = 3;

  typedef enum logic [3:0] {
    SRC_HOLD,
    SRC_UNARY,
    SRC_REGALU,
    SRC_REG,
    SRC_CMP,
    SRC_IMMLOG,
    SRC_IMMADD,
    SRC_BITOP,
    SRC_IMM
  } srcSel_t;

  typedef struct packed {
    srcSel_t            src;
    logic [SUB_W-1:0]   sub;
    logic               accWrite;
    logic               regWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/accOpDecode.sv
module accOpDecode
  import accAluPkg::*;
(
  input  logic [7:0]   opByte,
  input  logic [7:0]   immByte,
  output ctrlStrobes_t ctrl
);
  always_comb begin
    ctrl = '{src: SRC_HOLD, sub: '0, accWrite: 1'b0, regWrite: 1'b0};
    casez (opByte)
      8'b0000_1???: begin
        ctrl.src = SRC_UNARY; ctrl.sub = opByte[2:0]; ctrl.accWrite = 1'b1;
      end
      8'b0010_0???: begin
        ctrl.src = SRC_REG; ctrl.accWrite = 1'b1;
      end
      8'b0010_1???: begin
        ctrl.regWrite = 1'b1;
      end
      8'b0011_0???: begin
        ctrl.src = SRC_REG; ctrl.accWrite = 1'b1; ctrl.regWrite = 1'b1;
      end
      8'b0011_1???: begin
        ctrl.src = SRC_CMP; ctrl.accWrite = 1'b1;
      end
      8'b01??_????: begin
        ctrl.src = SRC_REGALU; ctrl.sub = opByte[5:3]; ctrl.accWrite = 1'b1;
      end
      8'b1111_00??: begin
        ctrl.accWrite = 1'b1;
        if (opByte[1:0] != 2'b11) begin
          ctrl.src = SRC_IMMLOG; ctrl.sub = {1'b0, opByte[1:0]};
        end else if (!immByte[7]) begin
          ctrl.src = SRC_IMMADD; ctrl.sub = 3'd0;
        end else if (immByte[6]) begin
          ctrl.src = SRC_IMMADD; ctrl.sub = 3'd1;
        end else begin
          ctrl.src = SRC_BITOP; ctrl.sub = immByte[5:3];
        end
      end
      8'b1111_1110: begin
        ctrl.src = SRC_IMM; ctrl.accWrite = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/accDatapath.sv
module accDatapath
  import accAluPkg::*;
(
  input  ctrlStrobes_t        ctrl,
  input  logic [7:0]          immByte,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   regIn,
  output logic [DATA_W-1:0]   accOut,
  output logic [DATA_W-1:0]   regOut
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam int SHORT_W = DATA_W - 1;

  logic [IDX_W-1:0]  regShift;
  logic [IDX_W-1:0]  immIdx;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] unaryRes;
  logic [DATA_W-1:0] regAluRes;
  logic [DATA_W-1:0] immLogRes;
  logic [DATA_W-1:0] immAddRes;
  logic [DATA_W-1:0] bitOpRes;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] rotRes;

  assign regShift = regIn[IDX_W-1:0];
  assign immIdx   = immByte[IDX_W-1:0];
  assign bitMask  = ONE << immIdx;

  // rotate built one output bit at a time
  for (genvar b = 0; b < DATA_W; b++) begin : g_rot
    assign rotRes[b] = accIn[(b - int'(immIdx) + DATA_W) % DATA_W];
  end

  always_comb begin
    case (ctrl.sub)
      3'd0: unaryRes = '0;
      3'd1: unaryRes = accIn << 1;
      3'd2: unaryRes = accIn >> 1;
      3'd3: unaryRes = {accIn[DATA_W-1], accIn[DATA_W-1:1]};
      3'd4: unaryRes = accIn + ONE;
      3'd5: unaryRes = accIn - ONE;
      3'd6: unaryRes = ~accIn;
      default: unaryRes = ~accIn + ONE;
    endcase
  end

  always_comb begin
    case (ctrl.sub)
      3'd0: regAluRes = accIn + regIn;
      3'd1: regAluRes = accIn - regIn;
      3'd2: regAluRes = accIn & regIn;
      3'd3: regAluRes = accIn | regIn;
      3'd4: regAluRes = accIn ^ regIn;
      3'd5: regAluRes = accIn << regShift;
      3'd6: regAluRes = accIn >> regShift;
      default: regAluRes = DATA_W'($signed(accIn) >>> regShift);
    endcase
  end

  always_comb begin
    case (ctrl.sub[1:0])
      2'd0:    immLogRes = accIn & immByte;
      2'd1:    immLogRes = accIn | immByte;
      default: immLogRes = accIn ^ immByte;
    endcase
  end

  assign addend    = ctrl.sub[0] ? immByte : {1'b0, immByte[SHORT_W-1:0]};
  assign immAddRes = accIn + addend;

  always_comb begin
    case (ctrl.sub)
      3'd0: bitOpRes = rotRes;
      3'd1: bitOpRes = accIn << immIdx;
      3'd2: bitOpRes = accIn >> immIdx;
      3'd3: bitOpRes = DATA_W'($signed(accIn) >>> immIdx);
      3'd4: bitOpRes = accIn & ~bitMask;
      3'd5: bitOpRes = accIn | bitMask;
      3'd6: bitOpRes = accIn ^ bitMask;
      default: bitOpRes = {{SHORT_W{1'b0}}, accIn[immIdx]};
    endcase
  end

  always_comb begin
    case (ctrl.src)
      SRC_UNARY:  accOut = unaryRes;
      SRC_REGALU: accOut = regAluRes;
      SRC_REG:    accOut = regIn;
      SRC_CMP:    accOut = {{SHORT_W{1'b0}}, accIn < regIn};
      SRC_IMMLOG: accOut = immLogRes;
      SRC_IMMADD: accOut = immAddRes;
      SRC_BITOP:  accOut = bitOpRes;
      SRC_IMM:    accOut = immByte;
      default:    accOut = accIn;
    endcase
  end

  assign regOut = ctrl.regWrite ? accIn : regIn;

  always_comb begin
    if (ctrl.src == SRC_CMP)
      assert_cmp_is_bool_R3: assert (accOut[DATA_W-1:1] == '0);
    if (ctrl.src == SRC_BITOP && ctrl.sub == 3'd6)
      assert_toggle_one_bit_R8: assert ($countones(accOut ^ accIn) == 1);
    if (ctrl.src == SRC_BITOP && ctrl.sub == 3'd7)
      assert_extract_low_only_R8: assert (accOut[DATA_W-1:1] == '0);
    if (ctrl.src == SRC_UNARY && ctrl.sub == 3'd6)
      assert_complement_all_bits_R1: assert ((accOut & accIn) == '0);
  end
endmodule

// File: rtl/accAluCore.sv
module accAluCore
  import accAluPkg::*;
(
  input  logic [7:0] opByte,
  input  logic [7:0] immByte,
  input  logic [7:0] accIn,
  input  logic [7:0] regIn,
  output logic [7:0] accOut,
  output logic       accWrite,
  output logic [7:0] regOut,
  output logic       regWrite
);
  ctrlStrobes_t ctrl;

  accOpDecode i_decode (
    .opByte  (opByte),
    .immByte (immByte),
    .ctrl    (ctrl)
  );

  accDatapath i_datapath (
    .ctrl    (ctrl),
    .immByte (immByte),
    .accIn   (accIn),
    .regIn   (regIn),
    .accOut  (accOut),
    .regOut  (regOut)
  );

  assign accWrite = ctrl.accWrite;
  assign regWrite = ctrl.regWrite;

  always_comb begin
    if (!accWrite)
      assert_acc_held_R10: assert (accOut == accIn);
    if (!regWrite)
      assert_reg_held_R10: assert (regOut == regIn);
    if (regWrite)
      assert_reg_write_only_moves_R4: assert (opByte[7:4] == 4'b0010 || opByte[7:3] == 5'b00110);
  end
endmodule

// File: tb/test_accAluCore.sv
module test_accAluCore;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] opByte, immByte, accIn, regIn;
  logic [7:0] accOut, regOut;
  logic       accWrite, regWrite;
  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  accAluCore i_accAluCore (
    .opByte(opByte), .immByte(immByte), .accIn(accIn), .regIn(regIn),
    .accOut(accOut), .accWrite(accWrite), .regOut(regOut), .regWrite(regWrite)
  );

  function automatic logic [7:0] shiftBy(input logic [7:0] v, input int n, input int kind);
    logic [7:0] t = v;
    for (int k = 0; k < n; k++) begin
      case (kind)
        0: t = {t[6:0], t[7]};
        1: t = {t[6:0], 1'b0};
        2: t = {1'b0, t[7:1]};
        default: t = {t[7], t[7:1]};
      endcase
    end
    return t;
  endfunction

  task automatic model(input logic [7:0] op, imm, a, r,
                       output logic [7:0] ea, output logic ew,
                       output logic [7:0] er, output logic erw,
                       output string req);
    int ai = a; int ri = r; int ii = imm; int n;
    ea = a; ew = 0; er = r; erw = 0; req = "R10";
    if (op[7:3] == 5'b00001) begin
      req = "R1"; ew = 1;
      case (op[2:0])
        0: ea = 0;
        1: ea = 8'((ai * 2) % 256);
        2: ea = 8'(ai / 2);
        3: ea = 8'(ai / 2 + (ai >= 128 ? 128 : 0));
        4: ea = 8'((ai + 1) % 256);
        5: ea = 8'((ai + 255) % 256);
        6: ea = 8'(255 - ai);
        default: ea = 8'((256 - ai) % 256);
      endcase
    end else if (op[7:3] == 5'b00100) begin
      req = "R4"; ew = 1; ea = r;
    end else if (op[7:3] == 5'b00101) begin
      req = "R4"; erw = 1; er = a;
    end else if (op[7:3] == 5'b00110) begin
      req = "R4"; ew = 1; erw = 1; ea = r; er = a;
    end else if (op[7:3] == 5'b00111) begin
      req = "R3"; ew = 1; ea = (ai < ri) ? 8'd1 : 8'd0;
    end else if (op[7:6] == 2'b01) begin
      req = "R2"; ew = 1; n = ri % 8;
      case (op[5:3])
        0: ea = 8'((ai + ri) % 256);
        1: ea = 8'((ai - ri + 256) % 256);
        2: ea = a & r;
        3: ea = a | r;
        4: ea = a ^ r;
        5: ea = shiftBy(a, n, 1);
        6: ea = shiftBy(a, n, 2);
        default: ea = shiftBy(a, n, 3);
      endcase
    end else if (op[7:2] == 6'b111100 && op[1:0] != 2'b11) begin
      req = "R5"; ew = 1;
      ea = (op[1:0] == 0) ? (a & imm) : (op[1:0] == 1) ? (a | imm) : (a ^ imm);
    end else if (op == 8'hF3) begin
      ew = 1;
      if (ii < 128) begin req = "R6"; ea = 8'((ai + ii) % 256); end
      else if (ii >= 192) begin req = "R7"; ea = 8'((ai + ii) % 256); end
      else begin
        req = "R8"; n = ii % 8;
        case ((ii / 8) % 8)
          0: ea = shiftBy(a, n, 0);
          1: ea = shiftBy(a, n, 1);
          2: ea = shiftBy(a, n, 2);
          3: ea = shiftBy(a, n, 3);
          4: begin ea = a; ea[n] = 1'b0; end
          5: begin ea = a; ea[n] = 1'b1; end
          6: begin ea = a; ea[n] = ~a[n]; end
          default: ea = {7'd0, a[n]};
        endcase
      end
    end else if (op == 8'hFE) begin
      req = "R9"; ew = 1; ea = imm;
    end
  endtask

  task automatic applyCheck(input logic [7:0] op, imm, a, r);
    logic [7:0] ea, er; logic ew, erw; string req;
    @(posedge clk); #1;
    opByte = op; immByte = imm; accIn = a; regIn = r;
    model(op, imm, a, r, ea, ew, er, erw, req);
    @(negedge clk);
    testCount++;
    if (accOut !== ea || accWrite !== ew || regOut !== er || regWrite !== erw) begin
      failCount++;
      $display("FAIL %s op=%h imm=%h a=%h r=%h: got acc=%h/%b reg=%h/%b expected acc=%h/%b reg=%h/%b",
               req, op, imm, a, r, accOut, accWrite, regOut, regWrite, ea, ew, er, erw);
    end
  endtask

  initial begin
    opByte = 0; immByte = 0; accIn = 0; regIn = 0;
    // R10: idle stop code with zero inputs
    applyCheck(8'h00, 8'h00, 8'h00, 8'h00);
    applyCheck(8'h00, 8'hFF, 8'h5A, 8'hA5);     // R10 stop ignores operands
    applyCheck(8'h0B, 8'h00, 8'h80, 8'h00);     // R1 asr1 keeps sign
    applyCheck(8'h0F, 8'h00, 8'h80, 8'h00);     // R1 negate 0x80
    applyCheck(8'h0D, 8'h00, 8'h00, 8'h00);     // R1 decrement wraps
    applyCheck(8'h7D, 8'h00, 8'h81, 8'h0A);     // R2 asr by low bits of reg
    applyCheck(8'h48, 8'h00, 8'h01, 8'h02);     // R2 subtract wraps
    applyCheck(8'h3B, 8'h00, 8'h40, 8'h40);     // R3 equal gives 0
    applyCheck(8'h3B, 8'h00, 8'h00, 8'hFF);     // R3 unsigned less-than
    applyCheck(8'h3B, 8'h00, 8'hFF, 8'h00);     // R3 not signed
    applyCheck(8'h2A, 8'h00, 8'h11, 8'h22);     // R4 store to register
    applyCheck(8'h33, 8'h00, 8'h11, 8'h22);     // R4 swap
    applyCheck(8'h21, 8'h00, 8'h11, 8'h22);     // R4 get register
    applyCheck(8'hF2, 8'hF0, 8'h3C, 8'h00);     // R5 xor immediate
    applyCheck(8'hF3, 8'h7F, 8'h90, 8'h00);     // R6 largest 7-bit add
    applyCheck(8'hF3, 8'hFF, 8'h00, 8'h00);     // R7 whole byte acts as -1
    applyCheck(8'hF3, 8'h83, 8'h81, 8'h00);     // R8 rotate left by 3
    applyCheck(8'hF3, 8'hBF, 8'h80, 8'h00);     // R8 extract bit 7
    applyCheck(8'hF3, 8'hB7, 8'h00, 8'h00);     // R8 toggle bit 7
    applyCheck(8'hF3, 8'hAD, 8'h00, 8'h00);     // R8 set bit 5
    applyCheck(8'hFE, 8'hC3, 8'h00, 8'h00);     // R9 load immediate
    applyCheck(8'hF4, 8'hFF, 8'h12, 8'h34);     // R10 unused two-byte form
    for (int i = 0; i < 4000; i++)
      applyCheck(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    for (int i = 0; i < 256; i++)               // R8 every bit-op code and index
      applyCheck(8'hF3, 8'h80 | 8'(i % 64), 8'($urandom), 8'h00);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      testCount++; failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule